// File: doc/BRIEF.md
# Power-State Clock Gating Window Controller

This block decides, cycle by cycle, whether the internal clock domains and the clock sent to the peripheral bus may be stopped while the link is parked in a low-power state. Software programs two sets of power-management action codes. One set covers the internal clocks. The other set covers the peripheral-bus clock and the internal grid that runs beside it. Each set is an 8-bit mask with one bit per code.

Decoded link broadcasts arrive on a small message port. A stop-grant message carries a 3-bit action code and opens a domain's gating window when that code is selected in the domain's mask. A clock-resume message closes both windows. The active-low link-stop input is brought in through a two-flop synchronizer. A domain gates only while its window is open and the synchronized link-stop is asserted. Link-stop pulses that arrive while the window is shut have no effect.

For the bus domain the block also produces the gated clock itself. A latch that is transparent while the clock is low holds the enable, so every high phase that reaches the output is complete and never truncated.

Top module: `clkgate_window_ctrl`

## Requirements
- R1: A stop-grant message (`msg_kind`=0) whose code `c` has `core_code_mask[c]`=1 opens the internal-clock window on the next clock edge.
- R2: A clock-resume message (`msg_kind`=1) closes both windows on the next clock edge, including while link-stop is asserted. `core_gate_en` and `bus_gate_en` then fall in that same cycle.
- R3: A stop-grant message whose code bit is clear in a domain's mask leaves that domain's window unchanged, whether it was open or closed.
- R4: `core_gate_en` is 1 exactly when the internal window is open and the synchronized link-stop is asserted. A link-stop assertion while the window is closed leaves both gate enables at 0 and the bus clock running.
- R5: The bus window opens from `bus_code_mask` independently of the internal window, and it drives `bus_gate_en` under the same rules.
- R6: `link_stop_n` is sampled through two flops, so a change driven before edge N shows on the gate enables after edge N+1.
- R7: While bus gating is in effect, `bus_clk_out` has no high phase. The first pulse removed is the one at edge N+2 after a change sampled at edge N. `bus_clk_out` is low during every low phase of `clk`.
- R8: When bus gating ends, full `bus_clk_out` pulses resume from edge N+2 after the releasing change was sampled at edge N.
- R9: An open window stays open across repeated link-stop assertions and releases until a clock-resume message arrives.
- R10: Reset closes both windows, holds both gate enables at 0 and leaves `bus_clk_out` following `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the source of the gated bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | A decoded broadcast is present this cycle |
| msg_kind | input | 1 | 0 = stop-grant, 1 = clock-resume |
| msg_code | input | 3 | Action code carried by a stop-grant |
| core_code_mask | input | 8 | Codes that open the internal-clock window |
| bus_code_mask | input | 8 | Codes that open the bus-clock window |
| link_stop_n | input | 1 | Asynchronous link-stop request, active low |
| core_gate_en | output | 1 | Internal clocks may be gated |
| bus_gate_en | output | 1 | Bus clock and its grid may be gated |
| bus_clk_out | output | 1 | Glitch-free gated copy of `clk` |

## Verification
A message driven before edge N changes the window at edge N. Its effect on the gate enables is therefore due in the low phase right after edge N. A link-stop change takes one more edge through the synchronizer, so its gate effect is due after edge N+1, and the matching change on `bus_clk_out` is due in the high phase that follows edge N+2. The driver records each expectation together with the cycle number at which it falls due. The monitors compare it only in that cycle: the enables in the low phase, the clock in the middle of its high phase. Every low phase is also checked for a stray high level on `bus_clk_out`.

// File: rtl/cgw_pkg.sv
package cgw_pkg;
  parameter int CODE_W = 3;
  localparam int NUM_CODES = 1 << CODE_W;
  parameter int SYNC_STAGES = 2;

  typedef enum logic {
    MSG_STOP_GRANT = 1'b0,
    MSG_CLK_RESUME = 1'b1
  } msg_kind_e;

  // Does the programmed set select this action code?
  function automatic logic code_selected(input logic [NUM_CODES-1:0] mask,
                                         input logic [CODE_W-1:0]    code);
    return mask[code];
  endfunction

  // Next window state from one decoded broadcast.
  function automatic logic window_next(input logic                 cur,
                                       input logic                 valid,
                                       input msg_kind_e            kind,
                                       input logic [NUM_CODES-1:0] mask,
                                       input logic [CODE_W-1:0]    code);
    if (!valid) return cur;
    if (kind == MSG_CLK_RESUME) return 1'b0;
    if (code_selected(mask, code)) return 1'b1;
    return cur;
  endfunction
endpackage

// File: rtl/cgw_sync.sv
module cgw_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cgw_window.sv
module cgw_window
  import cgw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 msg_valid,
  input  msg_kind_e            msg_kind,
  input  logic [CODE_W-1:0]    msg_code,
  input  logic [NUM_CODES-1:0] code_mask,
  input  logic                 stop_active,
  output logic                 win_open,
  output logic                 gate_en
);
  logic win_d;

  always_comb win_d = window_next(win_open, msg_valid, msg_kind, code_mask, msg_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_open <= 1'b0;
    else        win_open <= win_d;
  end

  assign gate_en = win_open & stop_active;
endmodule

// File: rtl/cgw_clk_gate.sv
module cgw_clk_gate (
  input  logic clk,
  input  logic run_en,
  output logic gclk
);
  logic en_held;

  // Enable may only change while the clock is low.
  always_latch begin
    if (!clk) en_held <= run_en;
  end

  assign gclk = clk & en_held;
endmodule

// File: rtl/clkgate_window_ctrl.sv
module clkgate_window_ctrl
  import cgw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 msg_valid,
  input  logic                 msg_kind,
  input  logic [CODE_W-1:0]    msg_code,
  input  logic [NUM_CODES-1:0] core_code_mask,
  input  logic [NUM_CODES-1:0] bus_code_mask,
  input  logic                 link_stop_n,
  output logic                 core_gate_en,
  output logic                 bus_gate_en,
  output logic                 bus_clk_out
);
  localparam int NUM_DOM = 2;   // 0: internal clocks, 1: bus clock

  logic                 stop_n_sync;
  logic                 stop_active;
  msg_kind_e            kind_q;
  logic [NUM_CODES-1:0] dom_mask [NUM_DOM];
  logic [NUM_DOM-1:0]   dom_win;
  logic [NUM_DOM-1:0]   dom_gate;
  logic                 core_win;
  logic                 bus_win;
  logic                 bus_run;

  cgw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_stop_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (link_stop_n),
    .q     (stop_n_sync)
  );

  assign stop_active = ~stop_n_sync;
  assign kind_q      = msg_kind_e'(msg_kind);
  assign dom_mask[0] = core_code_mask;
  assign dom_mask[1] = bus_code_mask;

  for (genvar gi = 0; gi < NUM_DOM; gi++) begin : g_dom
    cgw_window u_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .msg_valid   (msg_valid),
      .msg_kind    (kind_q),
      .msg_code    (msg_code),
      .code_mask   (dom_mask[gi]),
      .stop_active (stop_active),
      .win_open    (dom_win[gi]),
      .gate_en     (dom_gate[gi])
    );
  end

  assign core_win     = dom_win[0];
  assign bus_win      = dom_win[1];
  assign core_gate_en = dom_gate[0];
  assign bus_gate_en  = dom_gate[1];
  assign bus_run      = ~dom_gate[1];

  cgw_clk_gate u_bus_gate (
    .clk    (clk),
    .run_en (bus_run),
    .gclk   (bus_clk_out)
  );
endmodule

// File: rtl/cgw_checker.sv
module cgw_checker
  import cgw_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 msg_valid,
  input logic                 msg_kind,
  input logic [CODE_W-1:0]    msg_code,
  input logic [NUM_CODES-1:0] core_code_mask,
  input logic [NUM_CODES-1:0] bus_code_mask,
  input logic                 link_stop_n,
  input logic                 core_gate_en,
  input logic                 bus_gate_en,
  input logic                 core_win,
  input logic                 bus_win
);
  assert_open_on_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_kind && core_code_mask[msg_code]) |=> core_win);

  assert_close_on_resume_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind) |=> (!core_win && !bus_win && !core_gate_en && !bus_gate_en));

  assert_mismatch_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_kind && !core_code_mask[msg_code]) |=> $stable(core_win));

  assert_bus_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_kind && bus_code_mask[msg_code]) |=> bus_win);

  assert_gate_after_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_gate_en || bus_gate_en) |-> !$past(link_stop_n, 2));

  assert_window_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> ($stable(core_win) && $stable(bus_win)));
endmodule

bind clkgate_window_ctrl cgw_checker i_cgw_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .msg_valid      (msg_valid),
  .msg_kind       (msg_kind),
  .msg_code       (msg_code),
  .core_code_mask (core_code_mask),
  .bus_code_mask  (bus_code_mask),
  .link_stop_n    (link_stop_n),
  .core_gate_en   (core_gate_en),
  .bus_gate_en    (bus_gate_en),
  .core_win       (core_win),
  .bus_win        (bus_win)
);

// File: tb/test_clkgate_window_ctrl.sv
module test_clkgate_window_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       msg_valid = 1'b0;
  logic       msg_kind = 1'b0;
  logic [2:0] msg_code = 3'd0;
  logic [7:0] core_code_mask = 8'h21;  // codes 0 and 5
  logic [7:0] bus_code_mask  = 8'h04;  // code 2
  logic       link_stop_n = 1'b1;
  logic       core_gate_en, bus_gate_en, bus_clk_out;

  always #5 clk = ~clk;

  clkgate_window_ctrl i_clkgate_window_ctrl (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_kind(msg_kind),
    .msg_code(msg_code), .core_code_mask(core_code_mask),
    .bus_code_mask(bus_code_mask), .link_stop_n(link_stop_n),
    .core_gate_en(core_gate_en), .bus_gate_en(bus_gate_en),
    .bus_clk_out(bus_clk_out)
  );

  typedef struct { int due; logic core; logic bus; string tag; } gexp_t;
  typedef struct { int due; logic hi; string tag; } cexp_t;
  gexp_t gq[$];
  cexp_t cq[$];

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit win_c [512];
  bit win_b [512];
  bit stp   [512];
  bit done = 1'b0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  // Driver: one call per cycle; predicts from the requirements.
  task automatic step(input bit v, input bit kind, input logic [2:0] code,
                      input bit stop_n, input string tag);
    int n;
    bit cw, bw, s;
    @(negedge clk);
    n = cyc;
    msg_valid = v; msg_kind = kind; msg_code = code; link_stop_n = stop_n;
    cw = win_c[n % 512];
    bw = win_b[n % 512];
    if (v) begin
      if (kind) begin cw = 1'b0; bw = 1'b0; end
      else begin
        if (core_code_mask[code]) cw = 1'b1;
        if (bus_code_mask[code])  bw = 1'b1;
      end
    end
    win_c[(n + 1) % 512] = cw;
    win_b[(n + 1) % 512] = bw;
    stp[(n + 2) % 512] = !stop_n;
    s = stp[(n + 1) % 512];
    gq.push_back('{n + 1, cw & s, bw & s, tag});
    cq.push_back('{n + 2, !(bw & s), tag});
  endtask

  task automatic idle(input int k, input bit stop_n, input string tag);
    for (int i = 0; i < k; i++) step(1'b0, 1'b0, 3'd0, stop_n, tag);
  endtask

  // Monitor for enables and low-phase clock level.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && cyc > 0)
        chk(bus_clk_out == 1'b0, "R7", "bus_clk_out low phase", bus_clk_out, 0);
      while (gq.size() > 0 && gq[0].due <= cyc) begin
        gexp_t e;
        e = gq.pop_front();
        chk(core_gate_en == e.core, e.tag, "core_gate_en", core_gate_en, e.core);
        chk(bus_gate_en == e.bus, e.tag, "bus_gate_en", bus_gate_en, e.bus);
      end
    end
  end

  // Monitor for the high-phase bus clock.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (cq.size() > 0 && cq[0].due <= cyc) begin
        cexp_t e;
        e = cq.pop_front();
        chk(bus_clk_out == e.hi, e.tag, "bus_clk_out high phase", bus_clk_out, e.hi);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(core_gate_en == 1'b0, "R10", "core_gate_en in reset", core_gate_en, 0);
    chk(bus_gate_en == 1'b0, "R10", "bus_gate_en in reset", bus_gate_en, 0);
    @(posedge clk);
    #2;
    chk(bus_clk_out == 1'b1, "R10", "bus_clk_out runs in reset", bus_clk_out, 1);
    @(negedge clk);
    rst_n = 1'b1;
    cq.push_back('{1, 1'b1, "R10"});

    idle(3, 1'b1, "R10");
    // R4: link-stop with both windows closed has no effect
    idle(6, 1'b0, "R4");
    idle(3, 1'b1, "R4");
    // R3: non-matching code leaves closed windows closed
    step(1'b1, 1'b0, 3'd3, 1'b1, "R3");
    idle(6, 1'b0, "R3");
    idle(3, 1'b1, "R3");
    // R1: code 5 opens the internal window only
    step(1'b1, 1'b0, 3'd5, 1'b1, "R1");
    idle(2, 1'b1, "R1");
    idle(6, 1'b0, "R6");
    idle(4, 1'b1, "R6");
    // R2: resume closes it
    step(1'b1, 1'b1, 3'd0, 1'b1, "R2");
    idle(6, 1'b0, "R2");
    idle(3, 1'b1, "R2");
    // R5: code 2 opens the bus window only
    step(1'b1, 1'b0, 3'd2, 1'b1, "R5");
    idle(2, 1'b1, "R5");
    idle(7, 1'b0, "R7");
    idle(5, 1'b1, "R8");
    // R9: window persists across another stop period
    idle(6, 1'b0, "R9");
    // R3: non-matching code while open keeps it open
    step(1'b1, 1'b0, 3'd6, 1'b0, "R3");
    idle(3, 1'b0, "R3");
    // R2: resume while stopped releases gating and the clock
    step(1'b1, 1'b1, 3'd0, 1'b0, "R2");
    idle(5, 1'b0, "R2");
    idle(3, 1'b1, "R2");
    // Both windows together via code 0 and code 2
    step(1'b1, 1'b0, 3'd0, 1'b1, "R1");
    step(1'b1, 1'b0, 3'd2, 1'b1, "R5");
    idle(6, 1'b0, "R4");
    idle(5, 1'b1, "R8");
    step(1'b1, 1'b1, 3'd0, 1'b1, "R2");
    idle(4, 1'b1, "R2");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule